// File: doc/BRIEF.md
# Power-of-Two Staircase Up/Down Counter

A free-running counter that swings between two phases without any control input besides clock and reset. In the rising phase the output climbs by one on every clock, from zero to full scale. As soon as full scale is reached, the direction flag changes to falling.

In the falling phase each clock removes a power of two from the current value. The first removal is one, and every later removal is twice the one before it. With the default six-bit width the output runs 63, 62, 60, 56, 48, 32, 0. When the output lands on zero, the direction flag changes back to rising and the climb starts again.

The reset is synchronous and active high. It puts the output at zero and selects the rising direction. It also forgets how far a staircase had got, so a reset in the middle of a descent leaves no trace. After reset is released, counting resumes on the next clock with no further stimulus.

Top module: `pwr2_staircase_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `count_o` to 0 and `falling_o` to 0. `falling_o` = 0 means rising and 1 means falling.
- R2: While `falling_o` is 0, each clock edge without reset raises `count_o` by exactly one.
- R3: The edge that brings `count_o` to full scale (2^WIDTH-1, 63 by default) also sets `falling_o` to 1. The counter never wraps from full scale to zero by incrementing.
- R4: While `falling_o` is 1, the k-th edge after full scale subtracts 2^(k-1). With the defaults this gives the sequence 63, 62, 60, 56, 48, 32, 0.
- R5: Each falling step is taken from the value the output currently holds, never from full scale. The difference between two consecutive falling outputs is a single power of two, and it doubles on every step.
- R6: The edge that brings `count_o` to 0 during the falling phase also clears `falling_o`. The next edge without reset gives 1.
- R7: On the first edge after `rst` goes low, `count_o` becomes 1, with no other input.
- R8: A reset taken partway through a descent discards the stride progress. The next descent again starts by subtracting one (63 then 62).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| count_o | output | WIDTH | Registered count value |
| falling_o | output | 1 | Registered direction flag, 1 while descending |

## Verification
The bench runs long undisturbed stretches covering several full periods of 69 clocks. These show the increment path, the turn at full scale and the doubling descent, and they separate a true doubling stride from a decrement-by-one or a stride taken from full scale. Directed resets placed mid-descent and mid-climb show whether the stride exponent really clears, since a stale exponent would turn 63 into 55 or similar instead of 62. Random reset pulses, including multi-cycle ones and pulses on the turn cycles, probe the priority of reset over both direction changes.

// File: rtl/pwr2_staircase_pkg.sv
package pwr2_staircase_pkg;

  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } dir_e;

endpackage

// File: rtl/pwr2_stride_gen.sv
// Decodes a stride exponent into a one-hot power-of-two subtrahend.
module pwr2_stride_gen #(
  parameter int WIDTH = 6,
  parameter int EXP_W = $clog2(WIDTH)
) (
  input  logic [EXP_W-1:0] exp_i,
  output logic [WIDTH-1:0] stride_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign stride_o[b] = (exp_i == EXP_W'(b));
  end

endmodule

// File: rtl/pwr2_phase_ctrl.sv
// Holds the direction and the stride exponent.
module pwr2_phase_ctrl
  import pwr2_staircase_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_top_next_i,
  input  logic             at_floor_next_i,
  output dir_e             dir_o,
  output logic [EXP_W-1:0] exp_o
);

  dir_e             dir_q;
  logic [EXP_W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RISE;
      exp_q <= '0;
    end else begin
      unique case (dir_q)
        DIR_RISE: begin
          exp_q <= '0;
          if (at_top_next_i) begin
            dir_q <= DIR_FALL;
          end
        end
        DIR_FALL: begin
          if (at_floor_next_i) begin
            dir_q <= DIR_RISE;
            exp_q <= '0;
          end else begin
            exp_q <= exp_q + EXP_W'(1);
          end
        end
        default: begin
          dir_q <= DIR_RISE;
          exp_q <= '0;
        end
      endcase
    end
  end

  assign dir_o = dir_q;
  assign exp_o = exp_q;

endmodule

// File: rtl/pwr2_count_path.sv
// Count register with the increment / power-of-two subtract datapath.
module pwr2_count_path
  import pwr2_staircase_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] stride_i,
  output logic [WIDTH-1:0] count_o,
  output logic             at_top_next_o,
  output logic             at_floor_next_o
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    if (dir_i == DIR_FALL) begin
      cnt_d = cnt_q - stride_i;
    end else begin
      cnt_d = cnt_q + WIDTH'(1);
    end
  end

  // Turn detection works on the value about to be registered, so the
  // flag and the count change on the same edge.
  assign at_top_next_o   = (dir_i == DIR_RISE) && (cnt_q == FULL - WIDTH'(1));
  assign at_floor_next_o = (dir_i == DIR_FALL) && (cnt_q == stride_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/pwr2_staircase_counter.sv
module pwr2_staircase_counter
  import pwr2_staircase_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] count_o,
  output logic             falling_o
);

  localparam int EXP_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  dir_e             dir;
  logic [EXP_W-1:0] stride_exp;
  logic [WIDTH-1:0] stride;
  logic             at_top_next;
  logic             at_floor_next;

  pwr2_phase_ctrl #(
    .EXP_W(EXP_W)
  ) u_phase (
    .clk            (clk),
    .rst            (rst),
    .at_top_next_i  (at_top_next),
    .at_floor_next_i(at_floor_next),
    .dir_o          (dir),
    .exp_o          (stride_exp)
  );

  pwr2_stride_gen #(
    .WIDTH(WIDTH),
    .EXP_W(EXP_W)
  ) u_stride (
    .exp_i   (stride_exp),
    .stride_o(stride)
  );

  pwr2_count_path #(
    .WIDTH(WIDTH)
  ) u_path (
    .clk            (clk),
    .rst            (rst),
    .dir_i          (dir),
    .stride_i       (stride),
    .count_o        (count_o),
    .at_top_next_o  (at_top_next),
    .at_floor_next_o(at_floor_next)
  );

  assign falling_o = (dir == DIR_FALL);

endmodule

// File: rtl/pwr2_staircase_checker.sv
module pwr2_staircase_checker #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] count_o,
  input logic             falling_o
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(rst)) |-> (count_o == '0 && !falling_o)); // R1

  AST_RISE_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(rst) && !$past(falling_o)) |->
      (count_o == $past(count_o) + WIDTH'(1))); // R2

  AST_TOP_TURNS: assert property (@(posedge clk) disable iff (rst)
    (primed && count_o == FULL) |-> falling_o); // R3

  AST_FALL_POW2: assert property (@(posedge clk) disable iff (rst)
    (primed && falling_o && $past(falling_o)) |->
      ($countones(WIDTH'($past(count_o) - count_o)) == 1)); // R4

  AST_FLOOR_TURNS: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(falling_o) && !falling_o && !$past(rst)) |->
      (count_o == '0)); // R6

  AST_ZERO_RISING: assert property (@(posedge clk) disable iff (rst)
    (primed && count_o == '0) |-> !falling_o); // R6

endmodule

bind pwr2_staircase_counter pwr2_staircase_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .count_o  (count_o),
  .falling_o(falling_o)
);

// File: tb/pwr2_staircase_counter_test.sv
`timescale 1ns/1ps
module pwr2_staircase_counter_test;

  localparam int W    = 6;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] count_o;
  logic         falling_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int ref_cnt  = 0;
  bit ref_fall = 1'b0;
  int ref_k    = 0;
  bit was_rst  = 1'b1;
  bit mid_rst  = 1'b0;
  int prev_obs = 0;

  always #4 clk = ~clk;

  pwr2_staircase_counter #(.WIDTH(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .count_o  (count_o),
    .falling_o(falling_o)
  );

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock: drive rst away from the edge, advance the model, sample after the edge.
  task automatic step(input bit r);
    string tag;
    int    stride;
    bit    was_fall;
    @(negedge clk);
    rst = r;
    @(posedge clk);
    was_fall = ref_fall;
    stride   = 1 << ref_k;
    if (r) begin
      if (ref_fall) mid_rst = 1'b1;
      ref_cnt = 0; ref_fall = 1'b0; ref_k = 0;
      tag = "R1";
    end else if (!ref_fall) begin
      ref_cnt++;
      tag = was_rst ? "R7" : "R2";
      if (ref_cnt == FULL) begin
        ref_fall = 1'b1; ref_k = 0; tag = "R3";
      end
    end else begin
      ref_cnt -= stride;
      ref_k++;
      tag = (mid_rst && stride == 1) ? "R8" : "R4";
      if (stride == 1) mid_rst = 1'b0;
      if (ref_cnt == 0) begin
        ref_fall = 1'b0; ref_k = 0; tag = "R6";
      end
    end
    #2;
    check(tag, count_o == W'(ref_cnt), int'(count_o), ref_cnt);
    check({tag, " flag"}, falling_o == ref_fall, int'(falling_o), int'(ref_fall));
    // R5: a falling step is measured from the previous output
    if (!r && was_fall)
      check("R5", (prev_obs - int'(count_o)) == stride, prev_obs - int'(count_o), stride);
    prev_obs = int'(count_o);
    was_rst  = r;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // reset state, held for a few cycles
    for (int i = 0; i < 3; i++) step(1'b1);
    // two full undisturbed periods
    for (int i = 0; i < 150; i++) step(1'b0);
    // directed: reset mid-descent (after a few falling steps)
    while (!(ref_fall && ref_k == 3)) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 80; i++) step(1'b0);
    // directed: reset mid-climb
    for (int i = 0; i < 30; i++) step(1'b0);
    step(1'b1);
    step(1'b1);
    for (int i = 0; i < 75; i++) step(1'b0);
    // directed: reset exactly on the turn to falling
    while (ref_cnt != FULL - 1) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 70; i++) step(1'b0);
    // directed: reset exactly on the last falling step
    while (!(ref_fall && ref_cnt == 32)) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 70; i++) step(1'b0);
    // constrained random reset pulses
    for (int i = 0; i < 3000; i++) begin
      bit r;
      r = (($urandom() % 97) == 0);
      step(r);
      if (r && ($urandom() % 3 == 0)) step(1'b1);
    end
    // final clean period
    for (int i = 0; i < 140; i++) step(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule